// File: doc/BRIEF.md
# Bus-Inactivity Automatic Power-Down Controller

This block watches the address strobe of a microcontroller bus using a free-running peripheral clock. A counter measures how many clock periods pass with no new strobe pulse. Once the bus has been quiet for a set number of periods, and automatic power-down is enabled, the block enters a power-down state. In that state it asks every memory block to go to standby and cuts the address/data bus off from the memories and logic arrays. It also sets an output-enable for each port class.

In power-down, two configuration inputs can stop the microcontroller control signals and the common clock from reaching the logic arrays. Those gates never touch the clock that drives the idle counter. The block returns to normal operation when a new strobe pulse arrives, when chip-select is asserted (low), when the enable is cleared, or when reset is applied. The logic arrays and the I/O ports never receive a standby request, so their outputs can change without any wake-up delay.

Top module: `apd_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block leaves that edge in normal mode. After such an edge, `pd`, `bus_iso` and all `mem_stby` bits are 0, `ctrl_pass` and `clk_pass` are 1, all `port_oe` bits are 1, and the idle count restarts from zero.
- R2: With `apd_en` low, the block never enters power-down. A clock edge that samples `apd_en` low leaves `pd` at 0.
- R3: Power-down is entered on the 15th consecutive clock edge at which the idle condition holds. The idle condition is: `apd_en` high, `cs_n` high, and no strobe activity. After only 14 such edges, `pd` is still 0.
- R4: A rising edge on `strobe` passes through a two-flop synchroniser and an edge detector. It clears the idle count and `pd` at the third clock edge after the rise. A strobe that pulses more often than every 15 clock periods keeps the block out of power-down.
- R5: A clock edge that samples `cs_n` low clears `pd` and the idle count.
- R6: Every bit of `mem_stby` and the `bus_iso` output equal 1 exactly while `pd` is 1.
- R7: `ctrl_pass` is 0 only while `pd` is 1 and `blk_ctrl_en` is 1. `clk_pass` is 0 only while `pd` is 1 and `blk_clk_en` is 1. Setting `blk_clk_en` does not stop the idle count.
- R8: `port_oe` uses this bit order: bit 0 is microcontroller I/O, bit 1 is logic-array outputs, bit 2 is address-out, bit 3 is the data port, and bit 4 is peripheral I/O. In power-down, bits 3 and 4 are 0 (tri-stated) and bits 0 to 2 stay 1. Outside power-down, all five bits are 1.
- R9: Once in power-down, the block stays there for as long as the idle condition keeps holding. The counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running peripheral clock; never gated by this block |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Address strobe from the microcontroller; asynchronous to clk |
| cs_n | input | 1 | Active-low chip select; low forces normal mode |
| apd_en | input | 1 | Automatic power-down enable |
| blk_ctrl_en | input | 1 | Block control signals to the logic arrays while powered down |
| blk_clk_en | input | 1 | Block the common clock to the logic arrays while powered down |
| pd | output | 1 | Power-down flag |
| mem_stby | output | N_MEM | Standby request, one bit per memory |
| bus_iso | output | 1 | Isolate the address/data bus from memories and logic arrays |
| ctrl_pass | output | 1 | Enable for control signals into the logic arrays |
| clk_pass | output | 1 | Enable for the common clock into the logic arrays |
| port_oe | output | 5 | Output enable for each port class (bit order in R8) |

## Verification
The assertions assume that `cs_n`, `apd_en` and the blocking bits are synchronous to `clk`. They also assume that reset is held for at least one edge before the first checked cycle, so that `$past` of the counter refers to a state set by reset. The only input that is asynchronous is `strobe`. The assertions observe it after the synchroniser, so they only require each activity pulse to last one cycle.

The bench drives every input half a period away from the active edge. It holds reset for several cycles before it checks anything. It spaces strobe pulses widely enough that each rising edge produces exactly one activity pulse.

// File: rtl/apd_pkg.sv
// Shared definitions for the automatic power-down controller.
// Assumes: port-class indices below are the bit positions of port_oe.
package apd_pkg;
    localparam int PORT_CLASSES = 5;

    typedef enum int {
        PC_MCU_IO    = 0,
        PC_LOGIC_OUT = 1,
        PC_ADDR_OUT  = 2,
        PC_DATA      = 3,
        PC_PERIPH    = 4
    } port_class_e;

    // True for port classes that are tri-stated while powered down.
    function automatic logic floats_in_pd(int idx);
        return (idx == PC_DATA) || (idx == PC_PERIPH);
    endfunction
endpackage

// File: rtl/apd_strobe_sync.sv
// Brings the asynchronous address strobe into the clk domain.
// It uses a two-flop synchroniser followed by a rising-edge detector.
// Output: a one-cycle activity pulse for each rising edge seen.
// Assumes: the strobe stays high or low for at least two clk periods.
module apd_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic activity
);
    logic [1:0] sync_q;
    logic       last_q;

    // Synchronise the strobe, then keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], strobe_in};
            last_q <= sync_q[1];
        end
    end

    // Rising edge of the synchronised strobe.
    always_comb activity = sync_q[1] & ~last_q;

    // R4
    act_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !activity);
endmodule

// File: rtl/apd_idle_timer.sv
// Saturating idle counter and power-down flag.
// The counter advances on every clock edge where no wake condition holds.
// The flag is set on the edge where the counter reaches IDLE_LIMIT.
// Assumes: enable and cs_n are synchronous to clk.
module apd_idle_timer #(
    parameter int IDLE_LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cs_n,
    input  logic activity,
    output logic pd
);
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(IDLE_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             wake;

    // Wake sources: strobe activity, chip select, or the enable cleared.
    always_comb wake = activity | ~cs_n | ~enable;

    // Next count: clear on wake, otherwise count up and saturate.
    always_comb begin
        if (wake)
            cnt_next = '0;
        else if (cnt_q != LIMIT_C)
            cnt_next = cnt_q + CNT_W'(1);
        else
            cnt_next = cnt_q;
    end

    // Register the count and the flag; the flag follows the saturated count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pd    <= 1'b0;
        end else begin
            cnt_q <= cnt_next;
            pd    <= (cnt_next == LIMIT_C);
        end
    end

    // R2
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pd && cnt_q == '0));
    // R3
    entry_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd) |-> ($past(cnt_q) == LIMIT_C - CNT_W'(1)));
    // R4
    act_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !pd);
    // R5
    cs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> !pd);
    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && enable && cs_n && !activity) |=> pd);
endmodule

// File: rtl/apd_port_ctrl.sv
// Turns the power-down flag into standby requests, bus isolation,
// gating enables for the logic arrays, and output enables for each port class.
// Assumes: clk and rst_n are used only by the local checks.
module apd_port_ctrl
    import apd_pkg::*;
#(
    parameter int N_MEM = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pd,
    input  logic                    blk_ctrl_en,
    input  logic                    blk_clk_en,
    output logic [N_MEM-1:0]        mem_stby,
    output logic                    bus_iso,
    output logic                    ctrl_pass,
    output logic                    clk_pass,
    output logic [PORT_CLASSES-1:0] port_oe
);
    // One standby request per memory.
    for (genvar m = 0; m < N_MEM; m++) begin : g_mem
        assign mem_stby[m] = pd;
    end

    // Cut the bus off from the arrays while powered down.
    always_comb bus_iso = pd;

    // Gates into the logic arrays: closed only when powered down and the block bit is set.
    always_comb begin
        ctrl_pass = ~(pd & blk_ctrl_en);
        clk_pass  = ~(pd & blk_clk_en);
    end

    // For each port class: float it in power-down or keep it driven.
    for (genvar p = 0; p < PORT_CLASSES; p++) begin : g_port
        if (floats_in_pd(p)) begin : g_float
            assign port_oe[p] = ~pd;
        end else begin : g_hold
            assign port_oe[p] = 1'b1;
        end
    end

    // R8
    oe_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd |-> (&port_oe));
    // R8
    oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> (!port_oe[PC_DATA] && !port_oe[PC_PERIPH] && port_oe[PC_MCU_IO]));
    // R7
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_pass || !ctrl_pass) |-> pd);
    // R6
    stby_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iso |-> (&mem_stby));
endmodule

// File: rtl/apd_ctrl.sv
// Top of the automatic power-down controller.
// It chains the strobe synchroniser, the idle timer and the port/gate decode.
// Assumes: clk is free-running and is never gated by blk_clk_en.
module apd_ctrl
    import apd_pkg::*;
#(
    parameter int IDLE_LIMIT = 15,
    parameter int N_MEM      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic                    cs_n,
    input  logic                    apd_en,
    input  logic                    blk_ctrl_en,
    input  logic                    blk_clk_en,
    output logic                    pd,
    output logic [N_MEM-1:0]        mem_stby,
    output logic                    bus_iso,
    output logic                    ctrl_pass,
    output logic                    clk_pass,
    output logic [PORT_CLASSES-1:0] port_oe
);
    logic activity;

    apd_strobe_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (strobe),
        .activity  (activity)
    );

    apd_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (apd_en),
        .cs_n     (cs_n),
        .activity (activity),
        .pd       (pd)
    );

    apd_port_ctrl #(.N_MEM(N_MEM)) u_ports (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd          (pd),
        .blk_ctrl_en (blk_ctrl_en),
        .blk_clk_en  (blk_clk_en),
        .mem_stby    (mem_stby),
        .bus_iso     (bus_iso),
        .ctrl_pass   (ctrl_pass),
        .clk_pass    (clk_pass),
        .port_oe     (port_oe)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!pd && !bus_iso && ctrl_pass && clk_pass));
    // R6
    pd_entry_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_iso) |-> $past(cs_n && apd_en));
endmodule

// File: tb/apd_ctrl_test.sv
`timescale 1ns/1ps
// Bench for apd_ctrl.
// A behavioural reference model is compared with the design on every clock,
// and directed checks cover the corner cases.
module apd_ctrl_test;
    localparam int N_MEM = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic       cs_n = 1'b1;
    logic       apd_en = 1'b0;
    logic       blk_ctrl_en = 1'b0;
    logic       blk_clk_en = 1'b0;
    logic       pd;
    logic [N_MEM-1:0] mem_stby;
    logic       bus_iso, ctrl_pass, clk_pass;
    logic [4:0] port_oe;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    bit hist[3] = '{0, 0, 0};
    int idle = 0;
    bit m_pd = 1'b0;

    apd_ctrl #(.IDLE_LIMIT(15), .N_MEM(N_MEM)) uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .cs_n(cs_n), .apd_en(apd_en),
        .blk_ctrl_en(blk_ctrl_en), .blk_clk_en(blk_clk_en), .pd(pd),
        .mem_stby(mem_stby), .bus_iso(bus_iso), .ctrl_pass(ctrl_pass),
        .clk_pass(clk_pass), .port_oe(port_oe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model: a strobe rise is seen three edges later; an idle run of 15 edges enters power-down.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            idle = 0;
            m_pd = 1'b0;
        end else begin
            bit act;
            act = hist[1] && !hist[2];
            hist[2] = hist[1];
            hist[1] = hist[0];
            hist[0] = strobe;
            if (act || !cs_n || !apd_en) idle = 0;
            else if (idle < 15) idle++;
            m_pd = (idle == 15);
        end
    end

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 pd", pd, m_pd);
            chk("R6 mem_stby", mem_stby, {N_MEM{m_pd}});
            chk("R6 bus_iso", bus_iso, m_pd);
            chk("R7 ctrl_pass", ctrl_pass, !(m_pd && blk_ctrl_en));
            chk("R7 clk_pass", clk_pass, !(m_pd && blk_clk_en));
            chk("R8 port_oe", port_oe, m_pd ? 5'b00111 : 5'b11111);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        bit seen;
        tick(4);
        // R1: state while reset is held.
        chk("R1 pd", pd, 0);
        chk("R1 bus_iso", bus_iso, 0);
        chk("R1 port_oe", port_oe, 5'b11111);
        chk("R1 clk_pass", clk_pass, 1);
        cmp_on = 1'b1;
        apd_en = 1'b1;
        rst_n = 1'b1;
        // R3: 14 idle edges do not enter power-down; the 15th does.
        tick(14);
        chk("R3 no entry at 14", pd, 0);
        tick(1);
        chk("R3 entry at 15", pd, 1);
        chk("R6 standby", mem_stby, {N_MEM{1'b1}});
        chk("R8 data/periph float", port_oe, 5'b00111);
        // R9: stays in power-down while idle continues.
        tick(20);
        chk("R9 hold", pd, 1);
        // R4: wake by strobe, three edges after the rise.
        strobe = 1'b1;
        tick(2);
        chk("R4 not yet", pd, 1);
        tick(1);
        chk("R4 wake", pd, 0);
        strobe = 1'b0;
        tick(15);
        chk("R4 re-entry", pd, 1);
        // R7: blocking bits gate the array enables in power-down.
        blk_ctrl_en = 1'b1;
        blk_clk_en = 1'b1;
        tick(1);
        chk("R7 ctrl blocked", ctrl_pass, 0);
        chk("R7 clk blocked", clk_pass, 0);
        // R5: chip select wakes and holds off.
        cs_n = 1'b0;
        tick(1);
        chk("R5 wake", pd, 0);
        chk("R7 pass restored", clk_pass, 1);
        tick(20);
        chk("R5 held off", pd, 0);
        cs_n = 1'b1;
        // R7: clock blocking does not stop the timer.
        tick(15);
        chk("R7 timer runs while blocked", pd, 1);
        // R1: reset wakes.
        rst_n = 1'b0;
        tick(1);
        chk("R1 reset wake", pd, 0);
        rst_n = 1'b1;
        tick(15);
        chk("R1 re-entry after reset", pd, 1);
        // R2: enable low forces and keeps normal mode.
        apd_en = 1'b0;
        tick(1);
        chk("R2 exit", pd, 0);
        tick(40);
        chk("R2 no entry", pd, 0);
        apd_en = 1'b1;
        // R4: regular strobe pulses prevent entry.
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            strobe = 1'b1;
            tick(2);
            strobe = 1'b0;
            tick(8);
            if (pd) seen = 1'b1;
        end
        chk("R4 pulses keep awake", seen, 0);
        // R3: a strobe held high is idle too.
        strobe = 1'b1;
        tick(20);
        chk("R3 held-high strobe idles", pd, 1);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule